// File: doc/BRIEF.md
# Image line packetizer for a UDP sender

This block sits between a camera capture stage and a UDP transmit engine. On the pixel clock it takes 16-bit pixels, each marked by a valid strobe, along with a frame-sync level. It joins each pair of consecutive pixels into one 32-bit word. The words cross to the Ethernet transmit clock through an internal asynchronous FIFO. On the transmit side a small controller sends one image line per UDP payload. The first payload of every frame also carries a marker word and a word that holds the frame's width and height.

The sender interface works as follows. The block raises a one-cycle start pulse and presents a byte count at the same time. The sender then asks for words one at a time. When the payload is finished, the sender reports done. A run flag decides whether frames are sent at all. The flag is looked at only when a frame begins, so a frame is either sent whole or not sent at all.

Top module: `img_udp_packer`

## Requirements
- R1: Two consecutive valid pixels of a frame form one 32-bit word, with the earlier pixel in bits 31:16 and the later pixel in bits 15:0.
- R2: The first payload of each sent frame delivers the word 0xF0F0F0F0 first. Next comes a word with the line width in pixels in bits 31:16 and the line count in bits 15:0. The first line's words follow.
- R3: With `tx_start` the block sets `tx_byte_count` to 2×LINE_PIXELS+8 for the first payload of a frame and to 2×LINE_PIXELS for every other payload. The value holds until `tx_done`.
- R4: `tx_start` is high for one cycle at a time. It rises only when the FIFO holds at least one full line of words. After each `tx_req` sampled high, `tx_data` shows the next payload word in the following cycle.
- R5: Between a `tx_start` and the matching `tx_done` there is no further `tx_start`.
- R6: The run flag is sampled at the rising edge of `pix_vsync`. A frame that begins while the flag is 0 produces no payloads. A change of the flag during a frame has no effect on that frame.
- R7: Words reach `tx_data` in the order their pixels arrived. The FIFO is never written while full.
- R8: During reset `tx_start` is 0, `tx_byte_count` is 0 and `tx_data` is 0.
- R9: A rising edge of `pix_vsync` discards a pixel still waiting for its partner. Pairing restarts with the new frame's first pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pix_clk | input | 1 | Pixel clock |
| pix_rst_n | input | 1 | Active-low synchronous reset, pixel domain |
| pix_vsync | input | 1 | Frame sync; rising edge starts a frame |
| pix_valid | input | 1 | Pixel strobe |
| pix_data | input | 16 | Pixel value |
| run_flag | input | 1 | Enables frame sending (asynchronous, synchronised inside) |
| tx_clk | input | 1 | Ethernet transmit clock |
| tx_rst_n | input | 1 | Active-low synchronous reset, transmit domain |
| tx_req | input | 1 | Sender asks for the next payload word |
| tx_done | input | 1 | Sender finished the current payload |
| tx_start | output | 1 | One-cycle pulse starting a payload |
| tx_byte_count | output | 16 | Payload length in bytes |
| tx_data | output | 32 | Payload word, valid the cycle after a request |

## Verification
The assertions assume three things about the sender. It raises `tx_done` only after it has asked for every word of the payload. It never asks for more words than the byte count allows. It drains the FIFO faster than the camera fills it, so the FIFO never overflows. The bench models a sender that asks for exactly byte count / 4 words, one request every other cycle. It holds done back for several cycles after the last word. The stimulus sends short frames with gaps between lines, so the FIFO stays far from full. The run flag changes only away from vsync edges, so the sampled value is unambiguous.

// File: rtl/img_udp_pkg.sv
// Shared constants and types for the image line packetizer.
package img_udp_pkg;
    localparam int          PIX_W      = 16;
    localparam int          WORD_W     = 2 * PIX_W;
    localparam int          CNT_W      = 16;
    localparam int          HDR_BYTES  = 8;
    localparam logic [31:0] FRAME_MARK = 32'hF0F0_F0F0;

    // FIFO entry: a packed word plus a flag marking the first word of a frame
    typedef struct packed {
        logic              sof;
        logic [WORD_W-1:0] word;
    } fifo_item_t;

    typedef enum logic [1:0] {
        SND_IDLE = 2'd0,
        SND_DATA = 2'd1,
        SND_WAIT = 2'd2
    } snd_state_t;
endpackage

// File: rtl/sync_bus.sv
// Multi-stage synchroniser for a bus whose value changes one bit at a time.
// Assumes the source is a Gray-coded or single-bit registered signal.
module sync_bus #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            // Shift the sampled value one stage further into this domain
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= (g == 0) ? d : stage_q[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pix_pair_packer.sv
// Pixel-domain front end: detects frame starts, samples the run flag there,
// pairs pixels into 32-bit words and tags the first word of each frame.
// Assumes pixels arrive only between frame starts and that run_async is
// quasi-static around vsync edges.
module pix_pair_packer
    import img_udp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vsync,
    input  logic             valid,
    input  logic [PIX_W-1:0] data,
    input  logic             run_async,
    output logic             wr_en,
    output fifo_item_t       wr_item
);
    logic             run_s;
    logic             vsync_d;
    logic             frame_en;
    logic             half_full;
    logic [PIX_W-1:0] half_pix;
    logic             sof_pend;
    logic             vs_rise;

    sync_bus #(.W(1), .STAGES(2)) u_run_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (run_async),
        .q     (run_s)
    );

    assign vs_rise = vsync && !vsync_d;

    // Remember the previous vsync level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) vsync_d <= 1'b0;
        else        vsync_d <= vsync;
    end

    // Frame gating, pairing state and start-of-frame tag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_en  <= 1'b0;
            half_full <= 1'b0;
            half_pix  <= '0;
            sof_pend  <= 1'b0;
        end else if (vs_rise) begin
            frame_en  <= run_s;
            half_full <= 1'b0;
            sof_pend  <= 1'b1;
        end else if (valid && frame_en) begin
            if (!half_full) begin
                half_pix  <= data;
                half_full <= 1'b1;
            end else begin
                half_full <= 1'b0;
                sof_pend  <= 1'b0;
            end
        end
    end

    // Emit a completed word one cycle after its second pixel
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_item <= '0;
        end else begin
            wr_en        <= !vs_rise && valid && frame_en && half_full;
            wr_item.sof  <= sof_pend;
            wr_item.word <= {half_pix, data};
        end
    end
endmodule

// File: rtl/async_word_fifo.sv
// Dual-clock FIFO with Gray-coded pointers. The read side has show-ahead
// data and a conservative fill level. A write while full is dropped.
// Assumes AW >= 2.
module async_word_fifo #(
    parameter int W  = 33,
    parameter int AW = 10
) (
    input  logic         wr_clk,
    input  logic         wr_rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic         full,
    input  logic         rd_clk,
    input  logic         rd_rst_n,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic [AW:0]  rd_level
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wbin, wgray, rbin, rgray;
    logic [AW:0]  rgray_w, wgray_r;

    function automatic logic [AW:0] to_gray(input logic [AW:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [AW:0] from_gray(input logic [AW:0] g);
        logic [AW:0] b;
        b[AW] = g[AW];
        for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    sync_bus #(.W(AW+1), .STAGES(2)) u_rptr_sync (
        .clk (wr_clk), .rst_n (wr_rst_n), .d (rgray), .q (rgray_w)
    );
    sync_bus #(.W(AW+1), .STAGES(2)) u_wptr_sync (
        .clk (rd_clk), .rst_n (rd_rst_n), .d (wgray), .q (wgray_r)
    );

    assign full = (wgray == {~rgray_w[AW:AW-1], rgray_w[AW-2:0]});

    // Store accepted words
    always_ff @(posedge wr_clk) begin
        if (wr_en && !full) mem[wbin[AW-1:0]] <= wr_data;
    end

    // Advance the write pointer on each accepted word
    always_ff @(posedge wr_clk) begin
        if (!wr_rst_n) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (wr_en && !full) begin
            wbin  <= wbin + 1'b1;
            wgray <= to_gray(wbin + 1'b1);
        end
    end

    assign rd_level = from_gray(wgray_r) - rbin;
    assign rd_data  = mem[rbin[AW-1:0]];

    // Advance the read pointer on each pop of a present word
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n) begin
            rbin  <= '0;
            rgray <= '0;
        end else if (rd_en && (rd_level != '0)) begin
            rbin  <= rbin + 1'b1;
            rgray <= to_gray(rbin + 1'b1);
        end
    end
endmodule

// File: rtl/udp_line_sender.sv
// Transmit-domain controller. When a full line is buffered it starts a
// payload. A head word tagged as frame start gets the marker and the
// resolution word in front of it. Words are returned one per request.
// Assumes the sender requests exactly byte_count/4 words, then signals done.
module udp_line_sender
    import img_udp_pkg::*;
#(
    parameter int LINE_PIXELS = 640,
    parameter int FRAME_LINES = 480,
    parameter int AW          = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW:0]       level,
    input  fifo_item_t        head,
    output logic              pop,
    input  logic              tx_req,
    input  logic              tx_done,
    output logic              tx_start,
    output logic [CNT_W-1:0]  tx_byte_count,
    output logic [WORD_W-1:0] tx_data
);
    localparam int LINE_WORDS = LINE_PIXELS / 2;
    localparam int LINE_BYTES = LINE_PIXELS * 2;
    localparam int LEFT_W     = $clog2(LINE_WORDS + 3) + 1;
    localparam logic [WORD_W-1:0] RES_WORD =
        {16'(LINE_PIXELS), 16'(FRAME_LINES)};

    snd_state_t        state;
    logic              hdr_phase;
    logic              hdr_second;
    logic [LEFT_W-1:0] words_left;
    logic              line_ready;

    assign line_ready = ({1'b0, level} >= (AW+2)'(LINE_WORDS));
    assign pop        = (state == SND_DATA) && tx_req && !hdr_phase;

    // Payload sequencing: start, word delivery, wait for completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= SND_IDLE;
            hdr_phase     <= 1'b0;
            hdr_second    <= 1'b0;
            words_left    <= '0;
            tx_start      <= 1'b0;
            tx_byte_count <= '0;
            tx_data       <= '0;
        end else begin
            tx_start <= 1'b0;
            unique case (state)
                SND_IDLE: begin
                    if (line_ready) begin
                        tx_start      <= 1'b1;
                        hdr_phase     <= head.sof;
                        hdr_second    <= 1'b0;
                        tx_byte_count <= head.sof ? CNT_W'(LINE_BYTES + HDR_BYTES)
                                                  : CNT_W'(LINE_BYTES);
                        words_left    <= head.sof ? LEFT_W'(LINE_WORDS + 2)
                                                  : LEFT_W'(LINE_WORDS);
                        state         <= SND_DATA;
                    end
                end
                SND_DATA: begin
                    if (tx_req) begin
                        if (hdr_phase && !hdr_second) begin
                            tx_data    <= FRAME_MARK;
                            hdr_second <= 1'b1;
                        end else if (hdr_phase) begin
                            tx_data   <= RES_WORD;
                            hdr_phase <= 1'b0;
                        end else begin
                            tx_data <= head.word;
                        end
                        words_left <= words_left - 1'b1;
                        if (words_left == LEFT_W'(1)) state <= SND_WAIT;
                    end
                end
                SND_WAIT: begin
                    if (tx_done) state <= SND_IDLE;
                end
                default: state <= SND_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/img_udp_packer.sv
// Top level: pixel pairing, clock crossing and line-per-payload sending.
// Assumes LINE_PIXELS is even and the FIFO holds at least one line.
module img_udp_packer
    import img_udp_pkg::*;
#(
    parameter int LINE_PIXELS = 640,
    parameter int FRAME_LINES = 480,
    parameter int FIFO_AW     = 10
) (
    input  logic              pix_clk,
    input  logic              pix_rst_n,
    input  logic              pix_vsync,
    input  logic              pix_valid,
    input  logic [PIX_W-1:0]  pix_data,
    input  logic              run_flag,
    input  logic              tx_clk,
    input  logic              tx_rst_n,
    input  logic              tx_req,
    input  logic              tx_done,
    output logic              tx_start,
    output logic [CNT_W-1:0]  tx_byte_count,
    output logic [WORD_W-1:0] tx_data
);
    localparam int ITEM_W = $bits(fifo_item_t);

    logic          pk_wr;
    fifo_item_t    pk_item;
    logic          ff_full;
    logic          snd_pop;
    fifo_item_t    ff_head;
    logic [FIFO_AW:0] ff_level;

    pix_pair_packer u_packer (
        .clk       (pix_clk),
        .rst_n     (pix_rst_n),
        .vsync     (pix_vsync),
        .valid     (pix_valid),
        .data      (pix_data),
        .run_async (run_flag),
        .wr_en     (pk_wr),
        .wr_item   (pk_item)
    );

    async_word_fifo #(.W(ITEM_W), .AW(FIFO_AW)) u_fifo (
        .wr_clk   (pix_clk),
        .wr_rst_n (pix_rst_n),
        .wr_en    (pk_wr),
        .wr_data  (pk_item),
        .full     (ff_full),
        .rd_clk   (tx_clk),
        .rd_rst_n (tx_rst_n),
        .rd_en    (snd_pop),
        .rd_data  (ff_head),
        .rd_level (ff_level)
    );

    udp_line_sender #(
        .LINE_PIXELS (LINE_PIXELS),
        .FRAME_LINES (FRAME_LINES),
        .AW          (FIFO_AW)
    ) u_sender (
        .clk           (tx_clk),
        .rst_n         (tx_rst_n),
        .level         (ff_level),
        .head          (ff_head),
        .pop           (snd_pop),
        .tx_req        (tx_req),
        .tx_done       (tx_done),
        .tx_start      (tx_start),
        .tx_byte_count (tx_byte_count),
        .tx_data       (tx_data)
    );
endmodule

// File: rtl/img_udp_packer_chk.sv
// Protocol checker for the packetizer, attached by bind.
module img_udp_packer_chk #(
    parameter int LINE_PIXELS = 640
) (
    input logic        tx_clk,
    input logic        tx_rst_n,
    input logic        tx_start,
    input logic        tx_done,
    input logic [15:0] tx_byte_count,
    input logic        pix_clk,
    input logic        pix_rst_n,
    input logic        wr_req,
    input logic        wr_full
);
    localparam int LB = LINE_PIXELS * 2;

    logic busy;

    // Track an open payload from start to done, independent of the sender FSM
    always_ff @(posedge tx_clk) begin
        if (!tx_rst_n)     busy <= 1'b0;
        else if (tx_start) busy <= 1'b1;
        else if (tx_done)  busy <= 1'b0;
    end

    assert_start_single_R4: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
        tx_start |=> !tx_start);

    assert_one_in_flight_R5: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
        tx_start |-> !busy);

    assert_count_held_R3: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
        busy |-> $stable(tx_byte_count));

    assert_count_legal_R3: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
        tx_start |-> (tx_byte_count == 16'(LB) || tx_byte_count == 16'(LB + 8)));

    assert_no_overflow_R7: assert property (@(posedge pix_clk) disable iff (!pix_rst_n)
        wr_req |-> !wr_full);
endmodule

bind img_udp_packer img_udp_packer_chk #(.LINE_PIXELS(LINE_PIXELS)) u_chk (
    .tx_clk        (tx_clk),
    .tx_rst_n      (tx_rst_n),
    .tx_start      (tx_start),
    .tx_done       (tx_done),
    .tx_byte_count (tx_byte_count),
    .pix_clk       (pix_clk),
    .pix_rst_n     (pix_rst_n),
    .wr_req        (pk_wr),
    .wr_full       (ff_full)
);

// File: tb/img_udp_packer_bench.sv
// Scoreboard bench: the frame driver queues expected words and byte counts,
// and a sender model in the transmit domain pops and compares them.
module img_udp_packer_bench;
    localparam int LP = 8;
    localparam int FL = 3;
    localparam int LB = LP * 2;

    logic        pix_clk = 0, tx_clk = 0;
    logic        pix_rst_n = 0, tx_rst_n = 0;
    logic        pix_vsync = 0, pix_valid = 0, run_flag = 0;
    logic [15:0] pix_data = '0;
    logic        tx_req = 0, tx_done = 0;
    logic        tx_start;
    logic [15:0] tx_byte_count;
    logic [31:0] tx_data;

    int total = 0, bad = 0, starts = 0;
    bit finished = 0;
    logic [31:0] exp_words [$];
    int          exp_cnts  [$];

    always #5 pix_clk = ~pix_clk;
    always #2 tx_clk  = ~tx_clk;

    img_udp_packer #(.LINE_PIXELS(LP), .FRAME_LINES(FL), .FIFO_AW(5)) u_img_udp_packer (
        .pix_clk, .pix_rst_n, .pix_vsync, .pix_valid, .pix_data, .run_flag,
        .tx_clk, .tx_rst_n, .tx_req, .tx_done, .tx_start, .tx_byte_count, .tx_data
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one frame; queue expectations when it should be sent
    task automatic send_frame(input bit sent, input int seed, input bit odd_tail,
                              input bit flip_run);
        @(negedge pix_clk) pix_vsync = 1;
        repeat (3) @(negedge pix_clk);
        pix_vsync = 0;
        if (flip_run) run_flag = !run_flag;
        repeat (4) @(negedge pix_clk);
        if (sent) begin
            exp_words.push_back(32'hF0F0_F0F0);
            exp_words.push_back({16'(LP), 16'(FL)});
            exp_cnts.push_back(LB + 8);
            for (int l = 1; l < FL; l++) exp_cnts.push_back(LB);
        end
        for (int l = 0; l < FL; l++) begin
            for (int p = 0; p < LP; p += 2) begin
                logic [15:0] a, b;
                a = {4'(seed), 4'(l), 8'(p)};
                b = {4'(seed), 4'(l), 8'(p + 1)};
                if (sent) exp_words.push_back({a, b});
                pix_valid = 1; pix_data = a;
                @(negedge pix_clk);
                if (p == 2) begin pix_valid = 0; @(negedge pix_clk); end
                pix_valid = 1; pix_data = b;
                @(negedge pix_clk);
            end
            pix_valid = 0;
            repeat (6) @(negedge pix_clk);
        end
        if (odd_tail) begin
            pix_valid = 1; pix_data = 16'hDEAD;
            @(negedge pix_clk);
            pix_valid = 0;
        end
        repeat (4) @(negedge pix_clk);
    endtask

    // Sender model and scoreboard
    initial begin
        forever begin
            @(negedge tx_clk);
            if (tx_rst_n && tx_start) begin
                int n, ec;
                logic [15:0] cnt;
                starts++;
                cnt = tx_byte_count;
                ec  = (exp_cnts.size() > 0) ? exp_cnts.pop_front() : -1;
                check(int'(cnt) == ec, "R3/R6 byte count", 32'(cnt), 32'(ec));
                n = int'(cnt) / 4;
                for (int i = 0; i < n; i++) begin
                    logic [31:0] ew;
                    @(negedge tx_clk) tx_req = 1;
                    @(negedge tx_clk) tx_req = 0;
                    ew = (exp_words.size() > 0) ? exp_words.pop_front() : 32'hxxxx_xxxx;
                    check(tx_data === ew, "R1/R2/R4/R7/R9 word", tx_data, ew);
                end
                for (int w = 0; w < 6; w++) begin
                    @(negedge tx_clk);
                    check(tx_start == 1'b0, "R5 start before done", 32'(tx_start), 0);
                end
                check(tx_byte_count == cnt, "R3 count held", 32'(tx_byte_count), 32'(cnt));
                tx_done = 1;
                @(negedge tx_clk) tx_done = 0;
            end
        end
    end

    task automatic drain();
        int guard = 0;
        while ((exp_words.size() != 0 || exp_cnts.size() != 0) && guard < 20000) begin
            @(negedge tx_clk);
            guard++;
        end
        repeat (100) @(negedge tx_clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge tx_clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=%0d expected=0", exp_words.size());
        finish_run();
    end

    initial begin
        int s0;
        repeat (4) @(negedge pix_clk);
        // R8: reset state
        check(tx_start == 0, "R8 start in reset", 32'(tx_start), 0);
        check(tx_byte_count == 0, "R8 count in reset", 32'(tx_byte_count), 0);
        check(tx_data == 0, "R8 data in reset", tx_data, 0);
        pix_rst_n = 1; tx_rst_n = 1;
        run_flag = 1;
        repeat (10) @(negedge pix_clk);

        // Frame A sent, leaves an unpaired pixel (R9 checked by frame B words)
        send_frame(1, 1, 1, 0);
        // Frame B sent, then run flag cleared
        send_frame(1, 2, 0, 0);
        drain();
        run_flag = 0;
        repeat (10) @(negedge pix_clk);
        s0 = starts;
        // Frame C: disabled at start, flag raised mid-frame (R6)
        send_frame(0, 3, 0, 1);
        repeat (300) @(negedge tx_clk);
        check(starts == s0, "R6 disabled frame sent", 32'(starts), 32'(s0));
        repeat (10) @(negedge pix_clk);
        // Frame D: enabled at start, flag cleared mid-frame, still sent whole (R6)
        send_frame(1, 4, 0, 1);
        drain();
        s0 = starts;
        // Frame E: disabled
        send_frame(0, 5, 0, 0);
        repeat (300) @(negedge tx_clk);
        check(starts == s0, "R6 frame with flag 0", 32'(starts), 32'(s0));
        check(starts == 3 * FL, "R4 total payloads", 32'(starts), 32'(3 * FL));
        check(exp_words.size() == 0, "R7 words left unsent", 32'(exp_words.size()), 0);
        finish_run();
    end
endmodule